// File: doc/BRIEF.md
# Coprocessor Status and Control Register

This block is the control face of a coprocessor that can be stopped and started by a host. A host on a 32-bit word bus reads and writes a small set of registers. It uses them to run and stop the core, to clear its break condition and to raise or drop its interrupt request. It also uses them to keep eight general-purpose signal flags, to see whether the DMA engine is full or busy, to take and give back a hardware semaphore, and to load the program counter while the core is stopped. The core datapath and the DMA engine sit outside. They reach this block only through the strobes `step_i` and `brk_i` and the flags `dma_full_i` and `dma_busy_i`.

Status bits are never written directly. Each write to the status offset carries one set bit and one clear bit per status flag. A flag changes only when exactly one bit of its pair is asserted. A read of the semaphore offset returns its old value and takes the semaphore as a side effect.

The run state is a two-state machine. In ST_HALTED the core is stopped. In ST_RUNNING the core may step. Transition T_RESUME goes from ST_HALTED to ST_RUNNING on a status write that has clear-halt asserted and set-halt not asserted. Transition T_STOP goes from ST_RUNNING to ST_HALTED in two cases: on a write that has set-halt asserted and clear-halt not asserted, or on `brk_i`. In every other case the state holds.

Top module: `cop_ctrl`

## Requirements
- R1: After reset the status word reads 0x00000001 (only halt set, DMA inputs low), the PC reads 0, the semaphore is free, and `irq_o` and `err_o` are 0. Status read layout: bit0 halt, bit1 broke, bit2 DMA busy, bit3 DMA full, bit4 single-step, bit5 interrupt-on-break, bits 6..13 signal flags 0..7.
- R2: A write to offset 0x10 updates halt (clear bit0, set bit1), single-step (clear bit5, set bit6), interrupt-on-break (clear bit7, set bit8) and signal k (clear bit 9+2k, set bit 10+2k). A flag becomes 1 when only its set bit is asserted and 0 when only its clear bit is asserted. It keeps its value when both or neither are asserted.
- R3: Broke is cleared only by write bit2 at 0x10. Software cannot set it. `brk_i` while running sets broke, halts the core, and raises `irq_o` if interrupt-on-break is 1. `brk_i` while halted has no effect.
- R4: `irq_o` rises on a write to 0x10 that has bit4 asserted and bit3 not asserted. It falls when bit3 is asserted and bit4 is not. It is unchanged when both or neither are asserted.
- R5: A read at 0x14 returns the DMA-full flag in bit0 with other bits 0. A read at 0x18 always returns 0.
- R6: A read at 0x1C returns the semaphore value (0 free, 1 taken) and leaves it taken. Any write to 0x1C frees it.
- R7: A write to 0x20 loads the PC and the next-PC with the write data masked by 0xFFC, but only while halted. While running it is ignored. A read at 0x20 returns the PC.
- R8: While running, each `step_i` moves the PC to the next-PC and advances the next-PC by 4 modulo 4096. The first step after a PC load therefore leaves the PC unchanged.
- R9: An access to any other offset, or to an offset that is not word aligned, reads 0 and sets `err_o`, which stays 1 until reset.
- R10: Read data appears on `rsp_data` with `rsp_valid` high in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 6 | Byte offset |
| req_wdata | input | 32 | Write data |
| step_i | input | 1 | Core completed a step |
| brk_i | input | 1 | Core executed a break |
| dma_full_i | input | 1 | DMA request queue full |
| dma_busy_i | input | 1 | DMA transfer in progress |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| halted_o | output | 1 | Core is halted |
| sstep_o | output | 1 | Single-step flag |
| signal_o | output | 8 | Signal flags |
| irq_o | output | 1 | Interrupt request |
| pc_o | output | 12 | Program counter |
| err_o | output | 1 | Sticky unmapped-access flag |

## Verification
The set/clear word is tried in four forms for each flag: set only, clear only, both, and neither. This separates a correct pair decoder from one that gives either bit priority, and from one that writes the data bit straight into the flag. The PC is loaded while halted and then stepped, which shows whether the next-PC delay exists. It is also loaded while running and loaded near the top of the 4 KB window, which shows whether the halt gate and the wrap work. Reading the semaphore twice in a row, releasing it, and reading it again separates a read that takes the semaphore from a plain read. Break pulses are given both while running and while halted.

// File: rtl/cop_pkg.sv
package cop_pkg;
    typedef enum logic [0:0] {
        ST_HALTED  = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_t;

    localparam int OFS_STATUS = 'h10;
    localparam int OFS_DFULL  = 'h14;
    localparam int OFS_DBUSY  = 'h18;
    localparam int OFS_SEMA   = 'h1C;
    localparam int OFS_PC     = 'h20;

    localparam int WB_CLR_HALT  = 0;
    localparam int WB_SET_HALT  = 1;
    localparam int WB_CLR_BROKE = 2;
    localparam int WB_CLR_IRQ   = 3;
    localparam int WB_SET_IRQ   = 4;
    localparam int WB_CLR_SSTEP = 5;
    localparam int WB_SET_SSTEP = 6;
    localparam int WB_CLR_IOB   = 7;
    localparam int WB_SET_IOB   = 8;
    localparam int WB_SIG_BASE  = 9;

    localparam int RB_HALT     = 0;
    localparam int RB_BROKE    = 1;
    localparam int RB_DBUSY    = 2;
    localparam int RB_DFULL    = 3;
    localparam int RB_SSTEP    = 4;
    localparam int RB_IOB      = 5;
    localparam int RB_SIG_BASE = 6;
endpackage

// File: rtl/cop_run_fsm.sv
module cop_run_fsm
    import cop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_set,
    input  logic cmd_clr,
    input  logic brk,
    output logic halted
);
    run_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALTED:  if (cmd_clr && !cmd_set) state_d = ST_RUNNING;        // T_RESUME
            ST_RUNNING: if (brk || (cmd_set && !cmd_clr)) state_d = ST_HALTED; // T_STOP
            default:    state_d = ST_HALTED;
        endcase
    end

    always_comb halted = (state_q == ST_HALTED);

    assert_brk_halts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUNNING && brk) |=> (state_q == ST_HALTED));
endmodule

// File: rtl/cop_flag_bank.sv
module cop_flag_bank #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_cmd,
    input  logic [N-1:0] clr_cmd,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           q[i] <= 1'b0;
            else if (set_cmd[i] && !clr_cmd[i])   q[i] <= 1'b1;
            else if (clr_cmd[i] && !set_cmd[i])   q[i] <= 1'b0;
        end

        assert_flag_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (set_cmd[i] && clr_cmd[i]) |=> $stable(q[i]));
    end
endmodule

// File: rtl/cop_pc_unit.sv
module cop_pc_unit #(
    parameter int PC_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halted,
    input  logic            wr_req,
    input  logic [PC_W-1:0] wr_val,
    input  logic            step,
    output logic [PC_W-1:0] pc
);
    localparam logic [PC_W-1:0] PC_MASK = {{(PC_W-2){1'b1}}, 2'b00};
    localparam logic [PC_W-1:0] PC_INC  = PC_W'(4);

    logic [PC_W-1:0] pc_q, npc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            npc_q <= '0;
        end else if (halted && wr_req) begin
            pc_q  <= wr_val & PC_MASK;
            npc_q <= wr_val & PC_MASK;
        end else if (!halted && step) begin
            pc_q  <= npc_q;
            npc_q <= (npc_q + PC_INC) & PC_MASK;
        end
    end

    assign pc = pc_q;

    assert_pc_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !halted && !step) |=> $stable(pc_q));
endmodule

// File: rtl/cop_ctrl.sv
module cop_ctrl
    import cop_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int PC_W   = 12,
    parameter int NSIG   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              step_i,
    input  logic              brk_i,
    input  logic              dma_full_i,
    input  logic              dma_busy_i,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              halted_o,
    output logic              sstep_o,
    output logic [NSIG-1:0]   signal_o,
    output logic              irq_o,
    output logic [PC_W-1:0]   pc_o,
    output logic              err_o
);
    localparam int NFLAG = 2 + NSIG;
    localparam int FI_SSTEP = 0;
    localparam int FI_IOB   = 1;

    logic rd, wr, hit_status, hit_dfull, hit_dbusy, hit_sema, hit_pc, mapped;
    always_comb begin
        rd         = req_valid && !req_write;
        wr         = req_valid && req_write;
        hit_status = (int'(req_addr) == OFS_STATUS);
        hit_dfull  = (int'(req_addr) == OFS_DFULL);
        hit_dbusy  = (int'(req_addr) == OFS_DBUSY);
        hit_sema   = (int'(req_addr) == OFS_SEMA);
        hit_pc     = (int'(req_addr) == OFS_PC);
        mapped     = hit_status || hit_dfull || hit_dbusy || hit_sema || hit_pc;
    end

    logic wr_status;
    assign wr_status = wr && hit_status;

    // run state
    logic halted, brk_run;
    cop_run_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_set (wr_status && req_wdata[WB_SET_HALT]),
        .cmd_clr (wr_status && req_wdata[WB_CLR_HALT]),
        .brk     (brk_i),
        .halted  (halted)
    );
    assign brk_run = brk_i && !halted;

    // plain flags: single-step, interrupt-on-break, signals
    logic [NFLAG-1:0] fset, fclr, flags;
    always_comb begin
        fset = '0;
        fclr = '0;
        fset[FI_SSTEP] = wr_status && req_wdata[WB_SET_SSTEP];
        fclr[FI_SSTEP] = wr_status && req_wdata[WB_CLR_SSTEP];
        fset[FI_IOB]   = wr_status && req_wdata[WB_SET_IOB];
        fclr[FI_IOB]   = wr_status && req_wdata[WB_CLR_IOB];
    end
    for (genvar k = 0; k < NSIG; k++) begin : g_sig_cmd
        assign signal_cmd_set[k] = wr_status && req_wdata[WB_SIG_BASE + 2*k + 1];
        assign signal_cmd_clr[k] = wr_status && req_wdata[WB_SIG_BASE + 2*k];
    end
    logic [NSIG-1:0] signal_cmd_set, signal_cmd_clr;
    logic [NFLAG-1:0] fset_all, fclr_all;
    assign fset_all = fset | {signal_cmd_set, 2'b00};
    assign fclr_all = fclr | {signal_cmd_clr, 2'b00};

    cop_flag_bank #(.N(NFLAG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_cmd (fset_all),
        .clr_cmd (fclr_all),
        .q       (flags)
    );

    // broke, interrupt, semaphore, error
    logic broke_q, irq_q, sem_q, err_q;
    logic irq_set, irq_clr;
    always_comb begin
        irq_set = (wr_status && req_wdata[WB_SET_IRQ] && !req_wdata[WB_CLR_IRQ])
                  || (brk_run && flags[FI_IOB]);
        irq_clr = wr_status && req_wdata[WB_CLR_IRQ] && !req_wdata[WB_SET_IRQ];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            broke_q <= 1'b0;
            irq_q   <= 1'b0;
            sem_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (brk_run)                                   broke_q <= 1'b1;
            else if (wr_status && req_wdata[WB_CLR_BROKE]) broke_q <= 1'b0;
            if (irq_set)      irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;
            if (rd && hit_sema)      sem_q <= 1'b1;
            else if (wr && hit_sema) sem_q <= 1'b0;
            if (req_valid && !mapped) err_q <= 1'b1;
        end
    end

    // program counter
    logic [PC_W-1:0] pc;
    cop_pc_unit #(.PC_W(PC_W)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .halted (halted),
        .wr_req (wr && hit_pc),
        .wr_val (req_wdata[PC_W-1:0]),
        .step   (step_i),
        .pc     (pc)
    );

    // read port
    logic [DATA_W-1:0] status_word, rd_mux;
    always_comb begin
        status_word = '0;
        status_word[RB_HALT]  = halted;
        status_word[RB_BROKE] = broke_q;
        status_word[RB_DBUSY] = dma_busy_i;
        status_word[RB_DFULL] = dma_full_i;
        status_word[RB_SSTEP] = flags[FI_SSTEP];
        status_word[RB_IOB]   = flags[FI_IOB];
        for (int k = 0; k < NSIG; k++) status_word[RB_SIG_BASE + k] = flags[2 + k];
        rd_mux = '0;
        if (hit_status)    rd_mux = status_word;
        else if (hit_dfull) rd_mux[0] = dma_full_i;
        else if (hit_sema)  rd_mux[0] = sem_q;
        else if (hit_pc)    rd_mux[PC_W-1:0] = pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd;
            if (rd) rsp_data <= rd_mux;
        end
    end

    assign halted_o = halted;
    assign sstep_o  = flags[FI_SSTEP];
    assign signal_o = flags[NFLAG-1:2];
    assign irq_o    = irq_q;
    assign pc_o     = pc;
    assign err_o    = err_q;

    assert_broke_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(broke_q) |-> $past(brk_i));
    assert_irq_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && req_wdata[WB_SET_IRQ] && req_wdata[WB_CLR_IRQ] && !brk_run)
        |=> $stable(irq_q));
    assert_sem_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit_sema) |=> sem_q);
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    assert_read_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rsp_valid);
endmodule

// File: tb/sim_cop_ctrl.sv
module sim_cop_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        req_valid = 0, req_write = 0, step_i = 0, brk_i = 0;
    logic        dma_full_i = 0, dma_busy_i = 0;
    logic [5:0]  req_addr = 0;
    logic [31:0] req_wdata = 0;
    logic        rsp_valid, halted_o, sstep_o, irq_o, err_o;
    logic [31:0] rsp_data;
    logic [7:0]  signal_o;
    logic [11:0] pc_o;

    cop_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .step_i(step_i), .brk_i(brk_i),
        .dma_full_i(dma_full_i), .dma_busy_i(dma_busy_i), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .halted_o(halted_o), .sstep_o(sstep_o),
        .signal_o(signal_o), .irq_o(irq_o), .pc_o(pc_o), .err_o(err_o)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model state
    bit m_halt = 1, m_broke = 0, m_sstep = 0, m_iob = 0, m_irq = 0, m_sem = 0, m_err = 0;
    bit [7:0]  m_sig = 0;
    int        m_pc = 0, m_npc = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_status();
        logic [31:0] s = 0;
        s[0] = m_halt; s[1] = m_broke; s[2] = dma_busy_i; s[3] = dma_full_i;
        s[4] = m_sstep; s[5] = m_iob;
        for (int k = 0; k < 8; k++) s[6+k] = m_sig[k];
        return s;
    endfunction

    function automatic bit pair(bit cur, bit st, bit cl);
        if (st && !cl) return 1;
        if (cl && !st) return 0;
        return cur;
    endfunction

    task automatic compare_state();
        chk("R2 halt", 32'(halted_o), 32'(m_halt));
        chk("R2 sstep", 32'(sstep_o), 32'(m_sstep));
        chk("R2 signals", 32'(signal_o), 32'(m_sig));
        chk("R4 irq", 32'(irq_o), 32'(m_irq));
        chk("R8 pc", 32'(pc_o), m_pc);
        chk("R9 err", 32'(err_o), 32'(m_err));
    endtask

    // one bus cycle starting at a falling edge
    task automatic cyc(bit v, bit w, int a, logic [31:0] d, bit st, bit bk, string tag);
        bit rd, wr, ws, mapped, brun;
        logic [31:0] exp_rd;
        req_valid = v; req_write = w; req_addr = 6'(a); req_wdata = d;
        step_i = st; brk_i = bk;
        rd = v && !w; wr = v && w; ws = wr && a == 'h10;
        mapped = (a == 'h10 || a == 'h14 || a == 'h18 || a == 'h1C || a == 'h20);
        exp_rd = 0;
        if (a == 'h10) exp_rd = m_status();
        else if (a == 'h14) exp_rd = 32'(dma_full_i);
        else if (a == 'h1C) exp_rd = 32'(m_sem);
        else if (a == 'h20) exp_rd = m_pc;
        brun = bk && !m_halt;
        // next state from old state
        if (m_halt && wr && a == 'h20) begin
            m_pc = int'(d & 32'hFFC); m_npc = m_pc;
        end else if (!m_halt && st) begin
            m_pc = m_npc; m_npc = (m_npc + 4) & 'hFFC;
        end
        if (brun && m_iob) m_irq = 1;
        else if (ws) m_irq = pair(m_irq, d[4], d[3]);
        if (brun) m_broke = 1;
        else if (ws && d[2]) m_broke = 0;
        if (brun) m_halt = 1;
        else if (ws) m_halt = pair(m_halt, d[1], d[0]);
        if (ws) begin
            m_sstep = pair(m_sstep, d[6], d[5]);
            m_iob   = pair(m_iob, d[8], d[7]);
            for (int k = 0; k < 8; k++) m_sig[k] = pair(m_sig[k], d[10+2*k], d[9+2*k]);
        end
        if (rd && a == 'h1C) m_sem = 1;
        else if (wr && a == 'h1C) m_sem = 0;
        if (v && !mapped) m_err = 1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; step_i = 0; brk_i = 0;
        compare_state();
        if (rd) begin
            chk({tag, " R10 valid"}, 32'(rsp_valid), 1);
            chk(tag, rsp_data, exp_rd);
        end
    endtask

    task automatic wr_(int a, logic [31:0] d);  cyc(1, 1, a, d, 0, 0, "write"); endtask
    task automatic rd_(int a, string tag);      cyc(1, 0, a, 0, 0, 0, tag);     endtask
    task automatic step_();                     cyc(0, 0, 0, 0, 1, 0, "step");  endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare_state();                           // R1 reset outputs
        rd_('h10, "R1 reset status");
        rd_('h20, "R1 reset pc");
        rd_('h1C, "R1 sem free");
        wr_('h1C, 0);
        // R2 flag pairs
        wr_('h10, 32'h40);                         // set sstep
        wr_('h10, 32'h100);                        // set iob
        wr_('h10, 32'h400);                        // set sig0
        wr_('h10, 32'h600);                        // both sig0 -> keep
        wr_('h10, 32'h1_0000);                     // set sig3
        wr_('h10, 32'h60);                         // both sstep -> keep
        rd_('h10, "R2 status after pairs");
        wr_('h10, 32'h200);                        // clear sig0
        wr_('h10, 32'h0);                          // neither
        rd_('h10, "R2 status after clear");
        // R4 interrupt
        wr_('h10, 32'h10);
        wr_('h10, 32'h18);
        wr_('h10, 32'h08);
        wr_('h10, 32'h18);
        // R7 PC load while halted, both halt bits keep halt
        wr_('h10, 32'h3);
        wr_('h20, 32'h1237);
        rd_('h20, "R7 pc load masked");
        // R8 run and step
        wr_('h10, 32'h1);
        step_();
        step_();
        wr_('h20, 32'h0100);                       // ignored while running (R7)
        rd_('h20, "R7 pc write ignored");
        step_();
        // R3 break while running with iob set
        cyc(0, 0, 0, 0, 0, 1, "break");
        rd_('h10, "R3 status after break");
        cyc(0, 0, 0, 0, 0, 1, "break halted");     // no effect
        wr_('h10, 32'h4);                          // clear broke
        rd_('h10, "R3 broke cleared");
        wr_('h10, 32'h8);
        // R8 wrap
        wr_('h20, 32'hFFC);
        wr_('h10, 32'h1);
        step_();
        step_();
        step_();
        rd_('h20, "R8 pc wrap");
        wr_('h10, 32'h2);
        // R6 semaphore
        rd_('h1C, "R6 first take");
        rd_('h1C, "R6 second take");
        wr_('h1C, 32'h0);
        rd_('h1C, "R6 after release");
        // R5 DMA flags
        dma_full_i = 1; dma_busy_i = 1;
        rd_('h14, "R5 dma full");
        rd_('h18, "R5 zero offset");
        rd_('h10, "R5 status dma bits");
        dma_full_i = 0;
        rd_('h14, "R5 dma not full");
        dma_busy_i = 0;
        // R9 unmapped
        rd_('h04, "R9 unmapped read");
        rd_('h11, "R9 unaligned read");
        wr_('h30, 32'hFFFF_FFFF);
        rd_('h10, "R9 status intact");
        repeat (2) cyc(0, 0, 0, 0, 0, 0, "idle");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule